// File: doc/BRIEF.md
# Deserializer Lock Acquisition Controller

This controller sequences a serial-link receiver from power-down to valid parallel output. After power-down is released, it first waits for the local PLL to settle on the reference clock. It then watches the incoming serial stream for a transition word. For receivers with a spread-spectrum output stage, it can add a fixed settling delay before it declares lock. Once locked, it keeps checking that transition words keep arriving and that the line is still toggling. If either check fails, it falls back to searching.

The block does not drive the pads, PLLs or clock multiplexer itself. Instead it produces control levels for them:
- an active-low lock flag and an enable for that flag's driver;
- an enable and a force-low (blank) control for the data pins;
- a select for the parallel clock output, which picks the reference clock or the recovered clock;
- a one-cycle stretch request, so a downstream clock mux can widen the pulse around a clock swap.

All outputs are registered. Every input takes effect on the clock edge that samples it.

Top module: `dser_lock_ctrl`

## Requirements
- R1: While `pwr_down` is 1, on the next cycle `lock_oe` and `data_oe` are 0 (pins released), `lock_n` is 1, `data_blank` is 1 and `clk_sel` is 0. This holds from any state.
- R2: In the cycle after `pwr_down` is sampled 0 in power-down, the outputs are `lock_oe`=1, `data_oe`=1, `lock_n`=1, `data_blank`=1 and `clk_sel`=0 (0 selects the reference clock).
- R3: The reference-lock wait lasts `REF_LOCK_CYCLES` cycles, or ends after the first cycle in which `pll_ready` is 1. A `word_found` pulse during this wait has no effect on any output.
- R4: With `SETTLE_CYCLES`=0, a `word_found` sampled while searching makes `lock_n`=0, `data_blank`=0 and `clk_sel`=1 (recovered clock) on the next cycle.
- R5: With `SETTLE_CYCLES`>0, a `word_found` sampled while searching sets `clk_sel`=1 on the next cycle. `lock_n` stays 1 and `data_blank` stays 1 for `SETTLE_CYCLES` cycles, then `lock_n` goes 0.
- R6: While locked, if `WORD_TIMEOUT` consecutive cycles pass with no `word_found`, then `lock_n` returns to 1, `data_blank` to 1 and `clk_sel` to 0, and searching resumes.
- R7: A `word_found` while locked restarts the timeout window. This includes the last cycle of the window.
- R8: An `input_idle` sampled outside power-down and reference-lock gives `lock_n`=1, `data_blank`=1 and `clk_sel`=0 on the next cycle. It takes precedence over `word_found`.
- R9: `clk_stretch` is 1 in exactly those cycles in which `clk_sel` differs from its value in the cycle before.
- R10: `lock_n` is 0 only while `data_blank`=0, `clk_sel`=1 and both output enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_down | input | 1 | 1 forces power-down |
| pll_ready | input | 1 | Early end of the reference-lock wait |
| word_found | input | 1 | Pulse from the transition-word matcher |
| input_idle | input | 1 | Serial input detected as not switching |
| lock_n | output | 1 | Active-low lock flag; data valid only while 0 |
| lock_oe | output | 1 | Driver enable for the lock flag pin |
| data_oe | output | 1 | Driver enable for data and clock pins |
| data_blank | output | 1 | 1 forces data pins low |
| clk_sel | output | 1 | Parallel clock source: 0 reference, 1 recovered |
| clk_stretch | output | 1 | One-cycle pulse on each clock source change |

## Verification
Two functions can fall in the same cycle and need care. The first pair is the expiry of the word timeout and a fresh `word_found`. The bench provokes this with a directed gap of exactly `WORD_TIMEOUT-1` cycles and then a word, and requires that lock is kept. The second pair is `input_idle` and `word_found` in the same cycle, which the bench provokes both directed and at random; it requires the idle drop to win. Two instances run side by side, one with no settling delay and one with a delay. A cycle-level model in the bench judges every output of both instances on every cycle.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic [2:0] {
    ST_PDN     = 3'd0,
    ST_REFLOCK = 3'd1,
    ST_SEARCH  = 3'd2,
    ST_SETTLE  = 3'd3,
    ST_LOCKED  = 3'd4
  } dlc_state_e;
endpackage

// File: rtl/dlc_cnt.sv
module dlc_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dlc_fsm.sv
module dlc_fsm
  import dlc_pkg::*;
#(
  parameter bit HAS_SETTLE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_down,
  input  logic       pll_ready,
  input  logic       word_found,
  input  logic       input_idle,
  input  logic       ref_done,
  input  logic       settle_done,
  input  logic       win_done,
  output dlc_state_e state,
  output dlc_state_e state_nx
);
  dlc_state_e found_target;

  // the state entered on a transition word depends on the variant
  generate
    if (HAS_SETTLE) begin : g_settle
      assign found_target = ST_SETTLE;
    end else begin : g_direct
      assign found_target = ST_LOCKED;
    end
  endgenerate

  always_comb begin
    state_nx = state;
    if (pwr_down) begin
      state_nx = ST_PDN;
    end else begin
      case (state)
        ST_PDN:     state_nx = ST_REFLOCK;
        ST_REFLOCK: if (pll_ready || ref_done) state_nx = ST_SEARCH;
        ST_SEARCH:  if (!input_idle && word_found) state_nx = found_target;
        ST_SETTLE: begin
          if (input_idle)       state_nx = ST_SEARCH;
          else if (settle_done) state_nx = ST_LOCKED;
        end
        ST_LOCKED: begin
          if (input_idle)                  state_nx = ST_SEARCH;
          else if (!word_found && win_done) state_nx = ST_SEARCH;
        end
        default:    state_nx = ST_PDN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_PDN;
    else        state <= state_nx;
  end
endmodule

// File: rtl/dlc_outdec.sv
module dlc_outdec
  import dlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dlc_state_e state_nx,
  output logic       lock_n,
  output logic       lock_oe,
  output logic       data_oe,
  output logic       data_blank,
  output logic       clk_sel,
  output logic       clk_stretch
);
  logic powered_nx, valid_nx, sel_nx;

  always_comb begin
    powered_nx = (state_nx != ST_PDN);
    valid_nx   = (state_nx == ST_LOCKED);
    sel_nx     = (state_nx == ST_LOCKED) || (state_nx == ST_SETTLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_n      <= 1'b1;
      lock_oe     <= 1'b0;
      data_oe     <= 1'b0;
      data_blank  <= 1'b1;
      clk_sel     <= 1'b0;
      clk_stretch <= 1'b0;
    end else begin
      lock_n      <= !valid_nx;
      lock_oe     <= powered_nx;
      data_oe     <= powered_nx;
      data_blank  <= !valid_nx;
      clk_sel     <= sel_nx;
      clk_stretch <= (sel_nx != clk_sel);
    end
  end
endmodule

// File: rtl/dser_lock_ctrl.sv
module dser_lock_ctrl
  import dlc_pkg::*;
#(
  parameter int REF_LOCK_CYCLES = 16928,
  parameter int SETTLE_CYCLES   = 0,
  parameter int WORD_TIMEOUT    = 4194304
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic pll_ready,
  input  logic word_found,
  input  logic input_idle,
  output logic lock_n,
  output logic lock_oe,
  output logic data_oe,
  output logic data_blank,
  output logic clk_sel,
  output logic clk_stretch
);
  localparam int MAX_A  = (REF_LOCK_CYCLES > WORD_TIMEOUT) ? REF_LOCK_CYCLES : WORD_TIMEOUT;
  localparam int MAX_N  = (MAX_A > SETTLE_CYCLES) ? MAX_A : SETTLE_CYCLES;
  localparam int CW     = $clog2(MAX_N + 1);
  localparam bit HAS_ST = (SETTLE_CYCLES > 0);
  localparam logic [CW-1:0] REF_LAST = CW'(REF_LOCK_CYCLES - 1);
  localparam logic [CW-1:0] SET_LAST = CW'(HAS_ST ? SETTLE_CYCLES - 1 : 0);
  localparam logic [CW-1:0] WIN_LAST = CW'(WORD_TIMEOUT - 1);

  logic [1:0]    rst_sync;
  logic          srst_n;
  dlc_state_e    state, state_nx;
  logic [CW-1:0] cnt;
  logic          cnt_clr, cnt_en;
  logic          ref_done, settle_done, win_done;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  always_comb begin
    ref_done    = (cnt == REF_LAST);
    settle_done = (cnt == SET_LAST);
    win_done    = (cnt == WIN_LAST);
    cnt_clr     = (state_nx != state) || ((state == ST_LOCKED) && word_found);
    cnt_en      = (state != ST_PDN);
  end

  dlc_cnt #(.W(CW)) cnt_i (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .cnt   (cnt)
  );

  dlc_fsm #(.HAS_SETTLE(HAS_ST)) fsm_i (
    .clk         (clk),
    .rst_n       (srst_n),
    .pwr_down    (pwr_down),
    .pll_ready   (pll_ready),
    .word_found  (word_found),
    .input_idle  (input_idle),
    .ref_done    (ref_done),
    .settle_done (settle_done),
    .win_done    (win_done),
    .state       (state),
    .state_nx    (state_nx)
  );

  dlc_outdec out_i (
    .clk         (clk),
    .rst_n       (srst_n),
    .state_nx    (state_nx),
    .lock_n      (lock_n),
    .lock_oe     (lock_oe),
    .data_oe     (data_oe),
    .data_blank  (data_blank),
    .clk_sel     (clk_sel),
    .clk_stretch (clk_stretch)
  );
endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
  parameter int TIMEOUT = 16
) (
  input logic clk,
  input logic srst_n,
  input logic pwr_down,
  input logic word_found,
  input logic input_idle,
  input logic lock_n,
  input logic lock_oe,
  input logic data_oe,
  input logic data_blank,
  input logic clk_sel,
  input logic clk_stretch
);
  logic [31:0] win_q;

  // consecutive locked cycles without a transition word
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)                   win_q <= '0;
    else if (lock_n || word_found) win_q <= '0;
    else                           win_q <= win_q + 32'd1;
  end

  AST_PDN_HIZ: assert property (@(posedge clk) disable iff (!srst_n)
    pwr_down |=> (!lock_oe && !data_oe && lock_n)); // R1
  AST_PDN_RELEASE: assert property (@(posedge clk) disable iff (!srst_n)
    (!pwr_down && !lock_oe) |=> (lock_oe && data_oe && lock_n && data_blank && !clk_sel)); // R2
  AST_NO_EXPIRED_LOCK: assert property (@(posedge clk) disable iff (!srst_n)
    (win_q >= 32'(TIMEOUT)) |-> lock_n); // R6
  AST_WORD_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!srst_n)
    (!lock_n && word_found && !input_idle && !pwr_down) |=> !lock_n); // R7
  AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!srst_n)
    (input_idle && !pwr_down && lock_oe) |=> (lock_n && data_blank && !clk_sel)); // R8
  AST_STRETCH_ON_SWAP: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(clk_sel) |-> clk_stretch); // R9
  AST_STRETCH_ONLY_SWAP: assert property (@(posedge clk) disable iff (!srst_n)
    clk_stretch |-> !$stable(clk_sel)); // R9
  AST_LOCK_MEANS_VALID: assert property (@(posedge clk) disable iff (!srst_n)
    !lock_n |-> (!data_blank && clk_sel && lock_oe && data_oe)); // R10
endmodule

bind dser_lock_ctrl dlc_checker #(.TIMEOUT(WORD_TIMEOUT)) chk_i (
  .clk         (clk),
  .srst_n      (srst_n),
  .pwr_down    (pwr_down),
  .word_found  (word_found),
  .input_idle  (input_idle),
  .lock_n      (lock_n),
  .lock_oe     (lock_oe),
  .data_oe     (data_oe),
  .data_blank  (data_blank),
  .clk_sel     (clk_sel),
  .clk_stretch (clk_stretch)
);

// File: tb/dser_lock_ctrl_tb_top.sv
module dser_lock_ctrl_tb_top;
  localparam int REF_N = 20;
  localparam int TMO_N = 12;
  localparam int SET_N = 5;

  logic clk;
  logic rst_n, pwr_down, pll_ready, word_found, input_idle;
  logic [1:0] lock_n, lock_oe, data_oe, data_blank, clk_sel, clk_stretch;

  int    n_chk, n_fail;
  bit    done;
  string phase;

  // model: 0 power-down, 1 ref lock, 2 search, 3 settle, 4 locked
  int m_st  [2];
  int m_cnt [2];
  bit m_sel [2];
  bit m_selp[2];

  initial clk = 1'b0;
  always #2 clk = ~clk;

  dser_lock_ctrl #(.REF_LOCK_CYCLES(REF_N), .SETTLE_CYCLES(0), .WORD_TIMEOUT(TMO_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .pll_ready(pll_ready),
    .word_found(word_found), .input_idle(input_idle),
    .lock_n(lock_n[0]), .lock_oe(lock_oe[0]), .data_oe(data_oe[0]),
    .data_blank(data_blank[0]), .clk_sel(clk_sel[0]), .clk_stretch(clk_stretch[0]));

  dser_lock_ctrl #(.REF_LOCK_CYCLES(REF_N), .SETTLE_CYCLES(SET_N), .WORD_TIMEOUT(TMO_N)) dut_s_i (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .pll_ready(pll_ready),
    .word_found(word_found), .input_idle(input_idle),
    .lock_n(lock_n[1]), .lock_oe(lock_oe[1]), .data_oe(data_oe[1]),
    .data_blank(data_blank[1]), .clk_sel(clk_sel[1]), .clk_stretch(clk_stretch[1]));

  function automatic void model_step(int i, bit pd, bit rdy, bit wf, bit idl);
    int s   = m_st[i];
    int set = (i == 0) ? 0 : SET_N;
    int nx  = s;
    bit clr = 1'b0;
    if (pd) nx = 0;
    else begin
      case (s)
        0: nx = 1;
        1: if (rdy || m_cnt[i] == REF_N - 1) nx = 2;
        2: if (!idl && wf) nx = (set > 0) ? 3 : 4;
        3: if (idl) nx = 2; else if (m_cnt[i] == set - 1) nx = 4;
        4: if (idl) nx = 2; else if (wf) clr = 1'b1; else if (m_cnt[i] == TMO_N - 1) nx = 2;
        default: nx = 0;
      endcase
    end
    if (nx != s || clr) m_cnt[i] = 0;
    else if (s != 0)    m_cnt[i] = m_cnt[i] + 1;
    m_selp[i] = m_sel[i];
    m_sel[i]  = (nx == 3) || (nx == 4);
    m_st[i]   = nx;
  endfunction

  task automatic chk(string tag, string what, int i, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s inst%0d %s actual=%b expected=%b t=%0t", tag, i, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < 2; i++) begin
      chk(phase, "lock_oe",    i, lock_oe[i],    m_st[i] != 0);
      chk(phase, "data_oe",    i, data_oe[i],    m_st[i] != 0);
      chk(phase, "lock_n",     i, lock_n[i],     m_st[i] != 4);
      chk(phase, "data_blank", i, data_blank[i], m_st[i] != 4);
      chk(phase, "clk_sel",    i, clk_sel[i],    m_sel[i]);
      chk("R9",  "clk_stretch", i, clk_stretch[i], m_sel[i] != m_selp[i]);
      if (lock_n[i] === 1'b0)
        chk("R10", "valid_while_locked", i, (!data_blank[i] && clk_sel[i]), 1'b1);
    end
  endtask

  task automatic step(bit pd, bit rdy, bit wf, bit idl);
    pwr_down = pd; pll_ready = rdy; word_found = wf; input_idle = idl;
    model_step(0, pd, rdy, wf, idl);
    model_step(1, pd, rdy, wf, idl);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(int n, bit pd, bit rdy, bit wf, bit idl);
    for (int k = 0; k < n; k++) step(pd, rdy, wf, idl);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 2; i++) begin
      m_st[i] = 0; m_cnt[i] = 0; m_sel[i] = 1'b0; m_selp[i] = 1'b0;
    end
    rst_n = 1'b0; pwr_down = 1'b1; pll_ready = 1'b0; word_found = 1'b0; input_idle = 1'b0;
    repeat (3) @(negedge clk);
    phase = "R1";
    compare_all();                       // reset state
    rst_n = 1'b1;
    run(4, 1, 0, 0, 0);

    phase = "R2";
    step(0, 0, 0, 0);

    phase = "R3";                        // words during ref lock are ignored
    for (int k = 0; k < REF_N; k++) step(0, 0, (k % 3) == 0, 0);
    run(3, 0, 0, 0, 0);

    phase = "R4 R5";
    step(0, 0, 1, 0);
    run(8, 0, 0, 0, 0);

    phase = "R7";                        // regular words keep lock
    for (int k = 0; k < 4; k++) begin
      run(9, 0, 0, 0, 0);
      step(0, 0, 1, 0);
    end
    run(TMO_N - 1, 0, 0, 0, 0);          // word on the last cycle of the window
    step(0, 0, 1, 0);
    run(TMO_N - 1, 0, 0, 0, 0);
    step(0, 0, 1, 0);

    phase = "R6";
    run(TMO_N + 8, 0, 0, 0, 0);

    phase = "R8";
    step(0, 0, 1, 0);
    run(SET_N + 3, 0, 0, 0, 0);
    step(0, 0, 1, 1);                    // idle and word in the same cycle
    run(3, 0, 0, 0, 1);
    step(0, 0, 1, 1);                    // word while idle in search
    run(2, 0, 0, 0, 0);
    step(0, 0, 1, 0);
    run(2, 0, 0, 0, 0);
    step(0, 0, 0, 1);                    // idle during settle
    run(2, 0, 0, 0, 0);

    phase = "R1";
    step(0, 0, 1, 0);
    run(SET_N + 2, 0, 0, 0, 0);
    run(3, 1, 0, 1, 0);

    phase = "R3";                        // early end of ref lock
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    step(0, 1, 0, 0);
    step(0, 0, 1, 0);
    run(SET_N + 2, 0, 0, 0, 0);

    phase = "R8";                        // random mix
    for (int k = 0; k < 4000; k++) begin
      bit pd, rdy, wf, idl;
      pd  = ($urandom % 97) == 0;
      rdy = ($urandom % 16) == 0;
      wf  = ($urandom % 8)  == 0;
      idl = ($urandom % 40) == 0;
      step(pd, rdy, wf, idl);
    end

    done = 1'b1;
    finish_run();
  end
endmodule